// File: doc/BRIEF.md
# Masked Variable-Length Vector Lane Unit

This block is the integer execution engine of a vector core. It keeps a small file of vector registers, each holding 256 elements of 64 bits, and runs one element-wise operation (add, subtract or low half of a multiply) from two source registers into a destination register. The hardware has 32 lanes, so an operation walks through the register in beats of 32 elements, one beat per clock. How many elements take part is not part of the command. It comes from a vector length register that is loaded at runtime. That way, a loop tail shorter than the register costs only the beats it needs.

An optional 256-bit predicate mask can switch off single elements, so their destination elements keep their old values. Elements at or past the vector length are left alone in the same way. A packed flag splits every 64-bit slot into two separate 32-bit values. This doubles the number of operations per beat, and no carry or borrow passes between the two halves.

Commands arrive on a valid/ready stream. Ready is high only while the unit is idle, and the producer must hold a command and its valid until the cycle in which ready is seen. The unit has no further back-pressure. A one-cycle `done` pulse reports completion. Plain host ports load elements, the mask and the vector length while the unit is idle, and a combinational read port returns any element.

Top module: `vec_lane_unit`

## Requirements
- R1: The unit holds NREG registers of 256 x 64-bit elements, all zero after reset. While `cmd_ready` is high, `wr_en` writes `wr_data` to element `wr_elem` of register `wr_reg` at the clock edge. `rd_data` always shows element `rd_elem` of register `rd_reg`.
- R2: A command is taken at an edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while idle, so a `cmd_valid` held high during a running command starts nothing until the unit is idle again.
- R3: At an edge where `vl_we` and `cmd_ready` are both high, the vector length loads min(`vl_in`, 256). It resets to 0. A command uses the length held at the edge that accepts it.
- R4: An accepted command with vector length VL > 0 runs ceil(VL/32) beats. `done` is high for exactly one cycle, ceil(VL/32) cycles after the accepting edge, and `cmd_ready` is high again in the cycle after `done`.
- R5: A command with VL = 0 raises `done` in the cycle right after the accepting edge and changes no element.
- R6: Destination elements with index at or above VL keep their old values.
- R7: Opcode 0 computes a+b, 1 computes a-b, 2 computes the low 64 bits of a*b, and 3 computes a+b. All results wrap modulo 2^64.
- R8: The mask is loaded 32 bits at a time. `mask_we` writes `mask_word` into mask bits 32*`mask_sel` up to 32*`mask_sel`+31. With `cmd_mask_en`=1, element i (i < VL) is written only when mask bit i is 1. With `cmd_mask_en`=0, the mask is ignored.
- R9: With `cmd_packed`=1, bits [31:0] and [63:32] are computed independently modulo 2^32 (add, subtract, low 32 bits of the product), and no carry or borrow passes between them.
- R10: In packed mode, one mask bit enables or blocks both 32-bit halves of its element together.
- R11: While a command runs (`cmd_ready` low), `wr_en`, `mask_we` and `vl_we` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 2 | Operation code (R7) |
| cmd_dst | input | RW | Destination register |
| cmd_src_a | input | RW | First source register |
| cmd_src_b | input | RW | Second source register |
| cmd_mask_en | input | 1 | Apply predicate mask |
| cmd_packed | input | 1 | Two 32-bit values per slot |
| done | output | 1 | One-cycle completion pulse |
| vl_we | input | 1 | Load vector length |
| vl_in | input | 9 | New vector length |
| mask_we | input | 1 | Load one 32-bit mask word |
| mask_sel | input | 3 | Mask word index |
| mask_word | input | 32 | Mask word data |
| wr_en | input | 1 | Host element write |
| wr_reg | input | RW | Host write register |
| wr_elem | input | 8 | Host write element index |
| wr_data | input | 64 | Host write data |
| rd_reg | input | RW | Read register |
| rd_elem | input | 8 | Read element index |
| rd_data | output | 64 | Read data |

RW is 2 for the default of four registers.

## Verification
The hardest case to reach is a host write, mask load or length change that arrives while a command is still running. The bench must still prove that the write left no trace. To reach it, the bench starts a full-length command and drives all three host strobes in the cycle after acceptance. It then reads the target element back, and runs a masked command whose result shows that the old mask and the old length were used. The same reference model also follows a command whose valid is held high through two executions into a destination that is also a source, so a third, spurious acceptance would corrupt the result.

// File: rtl/vlu_pkg.sv
`timescale 1ns/1ps
package vlu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_ADD3 = 2'd3
  } vop_t;
endpackage

// File: rtl/vlu_lane.sv
`timescale 1ns/1ps
module vlu_lane
  import vlu_pkg::*;
#(
  parameter int EW = 64
) (
  input  vop_t          op,
  input  logic          pk,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] y
);
  localparam int HW = EW / 2;

  logic [EW-1:0] full;
  logic [HW-1:0] lo, hi;

  always_comb begin
    case (op)
      OP_SUB: begin
        full = a - b;
        lo   = a[HW-1:0] - b[HW-1:0];
        hi   = a[EW-1:HW] - b[EW-1:HW];
      end
      OP_MUL: begin
        full = a * b;
        lo   = a[HW-1:0] * b[HW-1:0];
        hi   = a[EW-1:HW] * b[EW-1:HW];
      end
      default: begin
        full = a + b;
        lo   = a[HW-1:0] + b[HW-1:0];
        hi   = a[EW-1:HW] + b[EW-1:HW];
      end
    endcase
    y = pk ? {hi, lo} : full;
  end
endmodule

// File: rtl/vlu_seq.sv
`timescale 1ns/1ps
module vlu_seq #(
  parameter int LANES = 32,
  parameter int ELEMS = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(ELEMS):0]       vl,
  output logic                         idle,
  output logic                         run,
  output logic [$clog2(ELEMS/LANES)-1:0] beat,
  output logic                         done
);
  localparam int LB  = $clog2(LANES);
  localparam int VLW = $clog2(ELEMS) + 1;
  localparam int BW  = $clog2(ELEMS / LANES);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;
  st_t state;
  logic [VLW-1:0] nb_q;
  logic [VLW-1:0] nb;

  assign nb = (vl + VLW'(LANES - 1)) >> LB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      beat  <= '0;
      nb_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          nb_q  <= nb;
          beat  <= '0;
          state <= (vl == '0) ? S_DONE : S_RUN;
        end
        S_RUN: begin
          if (VLW'(beat) + VLW'(1) == nb_q) state <= S_DONE;
          else beat <= beat + BW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idle = (state == S_IDLE);
  assign run  = (state == S_RUN);
  assign done = (state == S_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (VLW'(beat) < nb_q)); // R4
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && vl == '0) |=> done); // R5
endmodule

// File: rtl/vec_lane_unit.sv
`timescale 1ns/1ps
module vec_lane_unit
  import vlu_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int ELEMS = 256,
  parameter int LANES = 32,
  parameter int EW    = 64,
  localparam int RW   = $clog2(NREG),
  localparam int EIW  = $clog2(ELEMS),
  localparam int VLW  = $clog2(ELEMS) + 1,
  localparam int MSW  = $clog2(ELEMS / LANES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [1:0]     cmd_op,
  input  logic [RW-1:0]  cmd_dst,
  input  logic [RW-1:0]  cmd_src_a,
  input  logic [RW-1:0]  cmd_src_b,
  input  logic           cmd_mask_en,
  input  logic           cmd_packed,
  output logic           done,
  input  logic           vl_we,
  input  logic [VLW-1:0] vl_in,
  input  logic           mask_we,
  input  logic [MSW-1:0] mask_sel,
  input  logic [LANES-1:0] mask_word,
  input  logic           wr_en,
  input  logic [RW-1:0]  wr_reg,
  input  logic [EIW-1:0] wr_elem,
  input  logic [EW-1:0]  wr_data,
  input  logic [RW-1:0]  rd_reg,
  input  logic [EIW-1:0] rd_elem,
  output logic [EW-1:0]  rd_data
);
  logic [EW-1:0]    vrf [NREG][ELEMS];
  logic [ELEMS-1:0] mask_q;
  logic [VLW-1:0]   vl_q, vl_cmd;
  vop_t             op_q;
  logic [RW-1:0]    dst_q, sa_q, sb_q;
  logic             men_q, pk_q;

  logic             idle, run, accept;
  logic [MSW-1:0]   beat;

  logic [EIW-1:0]   eidx  [LANES];
  logic             lane_en [LANES];
  logic [EW-1:0]    lane_y [LANES];

  assign cmd_ready = idle;
  assign accept    = cmd_valid && idle;

  vlu_seq #(.LANES(LANES), .ELEMS(ELEMS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .vl(vl_q),
    .idle(idle), .run(run), .beat(beat), .done(done)
  );

  // command capture, length and mask registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q   <= '0;
      vl_cmd <= '0;
      mask_q <= '0;
      op_q   <= OP_ADD;
      dst_q  <= '0;
      sa_q   <= '0;
      sb_q   <= '0;
      men_q  <= 1'b0;
      pk_q   <= 1'b0;
    end else if (idle) begin
      if (accept) begin
        vl_cmd <= vl_q;
        op_q   <= vop_t'(cmd_op);
        dst_q  <= cmd_dst;
        sa_q   <= cmd_src_a;
        sb_q   <= cmd_src_b;
        men_q  <= cmd_mask_en;
        pk_q   <= cmd_packed;
      end
      if (vl_we) vl_q <= (vl_in > VLW'(ELEMS)) ? VLW'(ELEMS) : vl_in;
      if (mask_we) mask_q[int'(mask_sel)*LANES +: LANES] <= mask_word;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign eidx[l] = EIW'(int'(beat) * LANES + l);
    assign lane_en[l] = run && ({1'b0, eidx[l]} < vl_cmd) &&
                        (!men_q || mask_q[eidx[l]]);
    vlu_lane #(.EW(EW)) u_lane (
      .op(op_q), .pk(pk_q),
      .a(vrf[sa_q][eidx[l]]), .b(vrf[sb_q][eidx[l]]),
      .y(lane_y[l])
    );
  end

  // register file: host writes when idle, beat writeback when running
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < ELEMS; e++)
          vrf[r][e] <= '0;
    end else if (idle) begin
      if (wr_en) vrf[wr_reg][wr_elem] <= wr_data;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lane_en[l]) vrf[dst_q][eidx[l]] <= lane_y[l];
    end
  end

  assign rd_data = vrf[rd_reg][rd_elem];

  AST_VL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= VLW'(ELEMS)); // R3
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready); // R2
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready); // R4
  AST_HOST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !done) |=> $stable(vl_q) && $stable(mask_q)); // R11
endmodule

// File: tb/vec_lane_unit_test.sv
`timescale 1ns/1ps
module vec_lane_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0, cmd_mask_en = 0, cmd_packed = 0;
  logic [1:0]  cmd_op = 0, cmd_dst = 0, cmd_src_a = 0, cmd_src_b = 0;
  logic        vl_we = 0, mask_we = 0, wr_en = 0;
  logic [8:0]  vl_in = 0;
  logic [2:0]  mask_sel = 0;
  logic [31:0] mask_word = 0;
  logic [1:0]  wr_reg = 0, rd_reg = 0;
  logic [7:0]  wr_elem = 0, rd_elem = 0;
  logic [63:0] wr_data = 0;
  logic        cmd_ready, done;
  logic [63:0] rd_data;

  vec_lane_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a),
    .cmd_src_b(cmd_src_b), .cmd_mask_en(cmd_mask_en), .cmd_packed(cmd_packed),
    .done(done), .vl_we(vl_we), .vl_in(vl_in), .mask_we(mask_we),
    .mask_sel(mask_sel), .mask_word(mask_word), .wr_en(wr_en),
    .wr_reg(wr_reg), .wr_elem(wr_elem), .wr_data(wr_data),
    .rd_reg(rd_reg), .rd_elem(rd_elem), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;

  // ---------------- behavioural reference model ----------------
  logic [63:0]  m_vrf [4][256];
  logic [255:0] m_mask;
  int           m_vl;
  bit           m_pend;
  int           m_k;

  function automatic logic [63:0] ref_op(int op, bit pk, logic [63:0] a, logic [63:0] b);
    logic [31:0] l, h;
    if (!pk) begin
      if (op == 1) return a - b;
      if (op == 2) return a * b;
      return a + b;
    end
    if (op == 1) begin l = a[31:0] - b[31:0]; h = a[63:32] - b[63:32]; end
    else if (op == 2) begin l = a[31:0] * b[31:0]; h = a[63:32] * b[63:32]; end
    else begin l = a[31:0] + b[31:0]; h = a[63:32] + b[63:32]; end
    return {h, l};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 4; r++)
        for (int e = 0; e < 256; e++) m_vrf[r][e] = '0;
      m_mask = '0; m_vl = 0; m_pend = 0; m_k = 0;
    end else begin
      bit idle_now, acc;
      idle_now = !m_pend;
      acc = cmd_valid && idle_now;
      if (m_pend) begin
        if (m_k == 0) m_pend = 0; else m_k = m_k - 1;
      end
      if (idle_now) begin
        if (wr_en) m_vrf[wr_reg][wr_elem] = wr_data;
        if (mask_we) m_mask[mask_sel*32 +: 32] = mask_word;
      end
      if (acc) begin
        for (int i = 0; i < m_vl; i++)
          if (!cmd_mask_en || m_mask[i])
            m_vrf[cmd_dst][i] = ref_op(int'(cmd_op), cmd_packed,
                                       m_vrf[cmd_src_a][i], m_vrf[cmd_src_b][i]);
        m_pend = 1;
        m_k = (m_vl + 31) / 32;
      end
      if (idle_now && vl_we) m_vl = (vl_in > 256) ? 256 : int'(vl_in);
    end
  end

  // per-cycle comparison of handshake and completion (R2, R4)
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_done;
      exp_done = m_pend && (m_k == 0);
      checks++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL R4 done actual %b expected %b at %0t", done, exp_done, $time);
      end
      checks++;
      if (cmd_ready !== !m_pend) begin
        errors++;
        $display("FAIL R2 cmd_ready actual %b expected %b at %0t", cmd_ready, !m_pend, $time);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic host_wr(int r, int e, logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_reg = 2'(r); wr_elem = 8'(e); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_vl(int v);
    @(negedge clk); vl_we = 1; vl_in = 9'(v);
    @(negedge clk); vl_we = 0;
  endtask

  task automatic set_mask_word(int w, logic [31:0] d);
    @(negedge clk); mask_we = 1; mask_sel = 3'(w); mask_word = d;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic drive_cmd(int op, int dst, int sa, int sb, bit men, bit pk);
    cmd_op = 2'(op); cmd_dst = 2'(dst); cmd_src_a = 2'(sa); cmd_src_b = 2'(sb);
    cmd_mask_en = men; cmd_packed = pk; cmd_valid = 1;
  endtask

  task automatic issue(int op, int dst, int sa, int sb, bit men, bit pk);
    @(negedge clk);
    drive_cmd(op, dst, sa, sb, men, pk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify_reg(int r, string tag);
    for (int e = 0; e < 256; e++) begin
      @(negedge clk);
      rd_reg = 2'(r); rd_elem = 8'(e);
      #1;
      checks++;
      if (rd_data !== m_vrf[r][e]) begin
        errors++;
        $display("FAIL %s reg %0d elem %0d actual %h expected %h",
                 tag, r, e, rd_data, m_vrf[r][e]);
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state: R1 zero contents, idle and ready
    checks++;
    if (cmd_ready !== 1'b1 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset ready/done actual %b/%b expected 1/0", cmd_ready, done);
    end
    verify_reg(2, "R1_reset");

    // load source registers (R1)
    for (int e = 0; e < 256; e++) begin
      host_wr(1, e, {32'h8000_0000 ^ (32'(e) * 32'h0101_0101), 32'hFFFF_FFF0 + 32'(e)});
      host_wr(2, e, {32'h9000_0000 + 32'(e) * 7, 32'h0000_0020 + 32'(e)});
      host_wr(3, e, 64'(e) * 64'h0123_4567_89AB_CDEF);
    end
    verify_reg(1, "R1_write");

    // R4 R7: full-length add, 8 beats
    set_vl(256);
    issue(0, 0, 1, 2, 0, 0);
    verify_reg(0, "R7_add_full");

    // R6 R7: subtract with short length, tail of reg3 preserved
    set_vl(37);
    issue(1, 3, 1, 2, 0, 0);
    verify_reg(3, "R6_tail_sub");

    // R5: zero length writes nothing
    set_vl(0);
    issue(2, 1, 3, 2, 0, 0);
    verify_reg(1, "R5_zero_len");

    // R8: masked multiply
    for (int w = 0; w < 8; w++) set_mask_word(w, 32'hA5A5_0F0F ^ (32'(w) * 32'h1111_0001));
    set_vl(200);
    issue(2, 0, 3, 2, 1, 0);
    verify_reg(0, "R8_mask_mul");

    // R7 opcode 3, R8 mask disabled while mask nonzero
    set_vl(100);
    issue(3, 2, 1, 1, 0, 0);
    verify_reg(2, "R8_mask_off_op3");

    // R9: packed add with carries out of low half
    set_vl(256);
    issue(0, 3, 1, 2, 0, 1);
    verify_reg(3, "R9_packed_add");

    // R10: packed masked subtract (borrows)
    set_vl(150);
    issue(1, 0, 2, 1, 1, 1);
    verify_reg(0, "R10_packed_mask_sub");

    // R9: packed multiply
    set_vl(64);
    issue(2, 2, 1, 3, 0, 1);
    verify_reg(2, "R9_packed_mul");

    // R3: length above 256 clamps to 256
    set_vl(300);
    issue(0, 1, 0, 3, 0, 0);
    verify_reg(1, "R3_clamp");

    // R11: host strobes while busy are ignored
    set_vl(256);
    @(negedge clk);
    drive_cmd(0, 2, 3, 3, 0, 0);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    wr_en = 1; wr_reg = 2'd1; wr_elem = 8'd5; wr_data = 64'hDEAD_BEEF_0000_0001;
    mask_we = 1; mask_sel = 3'd0; mask_word = 32'hFFFF_FFFF;
    vl_we = 1; vl_in = 9'd7;
    @(negedge clk);
    wr_en = 0; mask_we = 0; vl_we = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    verify_reg(1, "R11_write_busy");
    issue(1, 3, 3, 1, 1, 0);
    verify_reg(3, "R11_mask_vl_busy");

    // R2: valid held through two executions, dst is also a source
    set_vl(96);
    @(negedge clk);
    drive_cmd(0, 1, 1, 2, 0, 0);
    begin
      int seen;
      seen = 0;
      while (seen < 2) begin
        @(negedge clk);
        if (done) seen++;
      end
    end
    cmd_valid = 0;
    while (!cmd_ready || done) @(negedge clk);
    repeat (6) @(negedge clk);
    verify_reg(1, "R2_held_valid");

    finish_run();
  end
endmodule